// File: doc/BRIEF.md
# Hard-Check Error Collector

This block gathers the error latches of a processor control unit into a single hard-check condition. Hard error sources count at once. Six soft error sources count only while a level-one-entered qualifier is on. The condition appears as a status bit that a service processor can read. The six soft latches are also exposed, so that the service processor can see which soft condition fired. A hard check sets a program-stop latch and an I/O-stop latch, and raises a high-level interrupt request toward the service processor.

Diagnostic controls let the service processor test the collection path:
- Either of two bypass inputs masks the hard-check condition and keeps the stop latches from setting.
- A check-reset input clears every error latch and both stop latches.
- An interrupt-disable input blocks the interrupt request.
- A clock-step mode freezes all state except on cycles where a step pulse is given. This lets diagnostics observe the error-latch-to-stop sequence one step at a time.

Top module: `hard_check_gather`

## Requirements
- R1: After a cycle with any bit of `hard_set_i` high, the following cycle shows `hard_check_o` = 1, unless a bypass input is on.
- R2: `soft_status_o` carries the soft latches. Bit 2 is I/O error, bit 3 invalid operation, bit 4 address exception on instruction fetch, bit 5 storage protect on instruction fetch, bit 6 address exception on program execution, and bit 7 storage protect on program execution. These map to `soft_set_i` bits 0 to 5 in the same order. Bits 1:0 read 0.
- R3: Set soft latches raise `hard_check_o` only while `lvl1_entered_i` = 1. While it is 0, they never raise it.
- R4: While `bypass_a_i` or `bypass_b_i` is 1, `hard_check_o` is 0, whatever latches are set.
- R5: `prog_stop_o` and `io_stop_o` set on the advancing cycle after the one in which `hard_check_o` is 1. They are sticky. They never set while a bypass hides the hard check, so a strobe sets the stops two advancing cycles after it is applied.
- R6: A cycle that advances with `chk_reset_i` = 1 clears all error latches and both stop latches. It wins over any set strobe in the same cycle.
- R7: Error latches are sticky. Once set, they stay set with the strobes low until check reset or system reset.
- R8: `svc_irq_o` = 1 while a hard latch is set, or a soft latch is set with `lvl1_entered_i` = 1, and `irq_disable_i` = 0. `irq_disable_i` = 1 forces it to 0. Bypass does not affect it.
- R9: While `step_mode_i` = 1, state changes only on cycles where `step_i` = 1. Strobes and check reset in other cycles have no effect.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_mode_i | input | 1 | Clock-step mode enable |
| step_i | input | 1 | Step pulse, used in clock-step mode |
| hard_set_i | input | NUM_HARD | Hard error set strobes |
| soft_set_i | input | 6 | Soft error set strobes (order as in R2) |
| lvl1_entered_i | input | 1 | Level-one-entered qualifier for soft errors |
| bypass_a_i | input | 1 | Bypass check stop, first source |
| bypass_b_i | input | 1 | Bypass check stop, second source |
| chk_reset_i | input | 1 | Check reset: clears error and stop latches |
| irq_disable_i | input | 1 | Blocks the interrupt request |
| hard_check_o | output | 1 | Hard-check status bit |
| soft_status_o | output | 8 | Soft-error status byte |
| prog_stop_o | output | 1 | Program-stop latch |
| io_stop_o | output | 1 | I/O-stop latch |
| svc_irq_o | output | 1 | High-level interrupt request to the service processor |

## Verification
The assertions check several properties on every cycle:
- the masking by either bypass source and by the interrupt disable;
- that soft latches cannot raise a hard check without the qualifier;
- that check reset empties the latch banks and the stop latches;
- that latches are sticky;
- that nothing moves on a non-step cycle.

Only the bench scenarios can show the following:
- the exact placement of each soft error in the status byte;
- the one-step delay between an error latch and the stops;
- the outcome when a set strobe and check reset arrive in the same cycle;
- the full step-by-step sequence in clock-step mode.

// File: rtl/hchk_pkg.sv
package hchk_pkg;
  localparam int SOFT_N   = 6;
  localparam int STAT_W   = 8;
  localparam int SOFT_LSB = STAT_W - SOFT_N;
  localparam int STOP_N   = 2;

  // Place soft latches in status bits SOFT_LSB upward; low bits read zero.
  function automatic logic [STAT_W-1:0] pack_soft(input logic [SOFT_N-1:0] s);
    logic [STAT_W-1:0] r;
    r = '0;
    r[SOFT_LSB +: SOFT_N] = s;
    return r;
  endfunction
endpackage

// File: rtl/hchk_rst_sync.sv
module hchk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hchk_err_bank.sv
module hchk_err_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] lat_o,
  output logic         any_o
);
  logic [W-1:0] lat_q, lat_d;

  // next state: check reset has priority over every set strobe
  always_comb begin
    if (clr_i) lat_d = '0;
    else       lat_d = lat_q | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lat_q <= '0;
    else if (adv_i) lat_q <= lat_d;
  end

  assign lat_o = lat_q;
  assign any_o = |lat_q;

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && clr_i |=> lat_q == '0);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !clr_i |=> (lat_q & $past(lat_q)) == $past(lat_q));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> lat_q == $past(lat_q));
endmodule

// File: rtl/hchk_condition.sv
module hchk_condition (
  input  logic hard_any_i,
  input  logic soft_any_i,
  input  logic lvl1_i,
  input  logic byp_a_i,
  input  logic byp_b_i,
  input  logic irq_dis_i,
  output logic hard_check_o,
  output logic irq_o
);
  logic qualified;
  logic bypassed;

  always_comb begin
    qualified    = hard_any_i | (soft_any_i & lvl1_i);
    bypassed     = byp_a_i | byp_b_i;
    hard_check_o = qualified & ~bypassed;
    irq_o        = qualified & ~irq_dis_i;
  end
endmodule

// File: rtl/hchk_stop_ctl.sv
module hchk_stop_ctl
  import hchk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic clr_i,
  input  logic hard_check_i,
  output logic prog_stop_o,
  output logic io_stop_o
);
  logic [STOP_N-1:0] stop_q, stop_d;

  for (genvar g = 0; g < STOP_N; g++) begin : g_stop
    always_comb begin
      if (clr_i) stop_d[g] = 1'b0;
      else       stop_d[g] = stop_q[g] | hard_check_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stop_q[g] <= 1'b0;
      else if (adv_i) stop_q[g] <= stop_d[g];
    end
  end

  assign prog_stop_o = stop_q[0];
  assign io_stop_o   = stop_q[1];

  p_stop_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && hard_check_i && !clr_i |=> prog_stop_o && io_stop_o);
  p_stop_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && clr_i |=> !prog_stop_o && !io_stop_o);
  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(prog_stop_o) && $stable(io_stop_o));
endmodule

// File: rtl/hard_check_gather.sv
module hard_check_gather
  import hchk_pkg::*;
#(
  parameter int NUM_HARD = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_mode_i,
  input  logic                step_i,
  input  logic [NUM_HARD-1:0] hard_set_i,
  input  logic [SOFT_N-1:0]   soft_set_i,
  input  logic                lvl1_entered_i,
  input  logic                bypass_a_i,
  input  logic                bypass_b_i,
  input  logic                chk_reset_i,
  input  logic                irq_disable_i,
  output logic                hard_check_o,
  output logic [STAT_W-1:0]   soft_status_o,
  output logic                prog_stop_o,
  output logic                io_stop_o,
  output logic                svc_irq_o
);
  logic                rst_q_n;
  logic                adv;
  logic [NUM_HARD-1:0] hard_lat;
  logic [SOFT_N-1:0]   soft_lat;
  logic                hard_any, soft_any;

  hchk_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  // clock enable: free-running, or one step per pulse in step mode
  assign adv = ~step_mode_i | step_i;

  hchk_err_bank #(.W(NUM_HARD)) u_hard (
    .clk(clk), .rst_n(rst_q_n), .adv_i(adv), .clr_i(chk_reset_i),
    .set_i(hard_set_i), .lat_o(hard_lat), .any_o(hard_any));

  hchk_err_bank #(.W(SOFT_N)) u_soft (
    .clk(clk), .rst_n(rst_q_n), .adv_i(adv), .clr_i(chk_reset_i),
    .set_i(soft_set_i), .lat_o(soft_lat), .any_o(soft_any));

  hchk_condition u_cond (
    .hard_any_i(hard_any), .soft_any_i(soft_any), .lvl1_i(lvl1_entered_i),
    .byp_a_i(bypass_a_i), .byp_b_i(bypass_b_i), .irq_dis_i(irq_disable_i),
    .hard_check_o(hard_check_o), .irq_o(svc_irq_o));

  hchk_stop_ctl u_stop (
    .clk(clk), .rst_n(rst_q_n), .adv_i(adv), .clr_i(chk_reset_i),
    .hard_check_i(hard_check_o), .prog_stop_o(prog_stop_o), .io_stop_o(io_stop_o));

  assign soft_status_o = pack_soft(soft_lat);

  p_hard_set_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    adv && !chk_reset_i && (|hard_set_i)
    |=> hard_check_o || bypass_a_i || bypass_b_i);
  p_soft_gate_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !lvl1_entered_i && hard_lat == '0 |-> !hard_check_o);
  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bypass_a_i || bypass_b_i) |-> !hard_check_o);
  p_irq_block_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_disable_i |-> !svc_irq_o);
endmodule

// File: tb/hard_check_gather_tb_top.sv
`timescale 1ns/1ps
module hard_check_gather_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_mode, step;
  logic [7:0] hard_set;
  logic [5:0] soft_set;
  logic       lvl1, byp_a, byp_b, chk_rst, irq_dis;
  logic       hc, pstop, iostop, irq;
  logic [7:0] sstat;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  hard_check_gather #(.NUM_HARD(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_mode_i(step_mode), .step_i(step),
    .hard_set_i(hard_set), .soft_set_i(soft_set), .lvl1_entered_i(lvl1),
    .bypass_a_i(byp_a), .bypass_b_i(byp_b), .chk_reset_i(chk_rst),
    .irq_disable_i(irq_dis), .hard_check_o(hc), .soft_status_o(sstat),
    .prog_stop_o(pstop), .io_stop_o(iostop), .svc_irq_o(irq));

  // [19:12] hard, [11:6] soft, [5] lvl1, [4] byp_a, [3] byp_b,
  // [2] irq_dis, [1] expected hard check, [0] expected irq
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {8'h01, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h80, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h00, 6'h3F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h00, 6'h3F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h00, 6'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h00, 6'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h10, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h10, 6'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h24, 6'h15, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; step_mode = 0; step = 0; hard_set = 0; soft_set = 0;
    lvl1 = 0; byp_a = 0; byp_b = 0; chk_rst = 0; irq_dis = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 outputs after reset", {hc, sstat, pstop, iostop, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      chk_rst = 1;
      lvl1 = VEC[i][5]; byp_a = VEC[i][4]; byp_b = VEC[i][3]; irq_dis = VEC[i][2];
      @(negedge clk);
      chk_rst = 0;
      hard_set = VEC[i][19:12]; soft_set = VEC[i][11:6];
      @(negedge clk);
      hard_set = 0; soft_set = 0;
      check($sformatf("R1/R3/R4 vec%0d hard check", i), hc, VEC[i][1]);
      check($sformatf("R8 vec%0d irq", i), irq, VEC[i][0]);
      check($sformatf("R2 vec%0d soft status", i), sstat, {VEC[i][11:6], 2'b00});
      check($sformatf("R5 vec%0d no stop yet", i), {pstop, iostop}, 2'b00);
      @(negedge clk);
      check($sformatf("R5 vec%0d stops", i), {pstop, iostop}, {VEC[i][1], VEC[i][1]});
    end

    // R7 stickiness
    @(negedge clk);
    chk_rst = 1; lvl1 = 0; byp_a = 0; byp_b = 0; irq_dis = 0;
    @(negedge clk);
    chk_rst = 0; hard_set = 8'h02;
    @(negedge clk);
    hard_set = 0;
    repeat (5) @(negedge clk);
    check("R7 latch held after strobe", hc, 1'b1);
    check("R7 stops held", {pstop, iostop}, 2'b11);

    // R6 check reset beats simultaneous set
    chk_rst = 1; hard_set = 8'hFF; soft_set = 6'h3F; lvl1 = 1;
    @(negedge clk);
    chk_rst = 0; hard_set = 0; soft_set = 0;
    check("R6 hard check cleared", hc, 1'b0);
    check("R6 soft status cleared", sstat, 8'h00);
    check("R6 stops cleared", {pstop, iostop}, 2'b00);
    lvl1 = 0;

    // R9 clock-step mode
    step_mode = 1; step = 0; hard_set = 8'h08;
    @(negedge clk);
    check("R9 no step no set", hc, 1'b0);
    step = 1;
    @(negedge clk);
    step = 0; hard_set = 0;
    check("R9 step sets latch", hc, 1'b1);
    check("R9 stops not yet", {pstop, iostop}, 2'b00);
    repeat (3) @(negedge clk);
    check("R9 stops wait for step", {pstop, iostop}, 2'b00);
    chk_rst = 1;
    @(negedge clk);
    chk_rst = 0;
    check("R9 check reset without step ignored", hc, 1'b1);
    step = 1;
    @(negedge clk);
    step = 0;
    check("R5 R9 stops one step later", {pstop, iostop}, 2'b11);
    step_mode = 0;

    done = 1;
    summary();
    $finish;
  end
endmodule